// File: doc/BRIEF.md
# Overlapped Block Input Sequencer

This block takes a stream of 16-bit samples and gathers them into blocks that a transform engine will process. The workspace is circular. Every accepted sample goes to the next address in the buffer, and the block reports where each finished block starts. With overlap selected, a new block is declared after only a half or a quarter of a block of new samples. The older part of the block is the retained tail of the previous one, so a full refill is not needed.

Loading only runs when the system allows it. A one-cycle start strobe arms the block for exactly one block's worth of new samples. While the block is not armed, samples are dropped. When the block fills, a one-cycle ready pulse is issued together with the block's base address. Each sample is stored as one 32-bit word. In complex mode the word holds a real and an imaginary part. In real-only mode it holds two independent real streams, one in each half. The transform side reads the workspace through a registered read port.

Top module: `ovlp_block_loader`

## Requirements
- R1: After reset, `busy` and `blk_rdy` are low and `blk_base` is zero. The first word written after reset goes to address 0.
- R2: A `load_go` pulse seen while idle makes `busy` high from the next cycle. A sample offered with `in_vld` while `busy` is low is neither stored nor counted. This includes a sample offered in the same cycle as that `load_go`.
- R3: Accepted samples are written in arrival order to consecutive workspace addresses, modulo the depth of 2048 words. Each load continues from the address where the last one ended.
- R4: The stored word has `in_re` in bits [15:0]. Bits [31:16] hold `in_im` when `cfg_real` is 0 and `in_aux` when `cfg_real` is 1. The mode is taken per sample.
- R5: The block length N is 128 << `cfg_size` (codes 0..3 give 128, 256, 512 and 1024). No ready pulse is issued before the required count of samples has been accepted.
- R6: The first block after reset needs N accepted samples whatever the overlap setting. Its base is the address of its first sample.
- R7: `cfg_ovl` selects the overlap: 2'b00 gives none, 2'b01 gives 50%, 2'b10 gives 75%, and 2'b11 is treated as none. A later block with unchanged settings needs N, N/2 or N/4 new samples, and its base is the previous base plus that step, modulo 2048.
- R8: `blk_rdy` is high for exactly one cycle, in the cycle after the clock edge that accepts the last sample of a block. `blk_base` is valid with it and holds until the next pulse.
- R9: A `load_go` in the cycle that accepts a block's last sample starts the next load with no idle cycle, so `busy` stays high. A `load_go` at any other time while `busy` is high is ignored.
- R10: A load started with a size or overlap different from the previous load's is treated like the first block. It needs N samples, and its base is the current write address.
- R11: `rd_data` shows the workspace word at `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_go | input | 1 | Start strobe for one load |
| in_vld | input | 1 | Sample present on the data inputs |
| in_re | input | 16 | Real sample, or first real stream |
| in_im | input | 16 | Imaginary sample (complex mode) |
| in_aux | input | 16 | Second real stream (real-only mode) |
| cfg_real | input | 1 | 1 selects real-only packing |
| cfg_size | input | 2 | Block length code |
| cfg_ovl | input | 2 | Overlap code |
| rd_addr | input | 11 | Workspace read address |
| busy | output | 1 | A load is armed |
| blk_rdy | output | 1 | One-cycle block-complete pulse |
| blk_base | output | 11 | Start address of the completed block |
| rd_data | output | 32 | Workspace read data |

## Verification
The cycle that accepts a block's last sample can also carry a new start strobe. In that one cycle the load completes, the start pointer moves by the step, and the next load is armed. The bench drives `load_go` exactly on that final sample in chained runs. It then judges three things: `blk_rdy` pulses once, `busy` never drops, and the base of the block after that matches the start plus a whole number of steps. A strobe placed mid-load, in a cycle with no completion, must leave the sample count and the ready timing unchanged.

// File: rtl/olb_pkg.sv
package olb_pkg;

    typedef enum logic [1:0] {
        OVL_NONE    = 2'b00,
        OVL_HALF    = 2'b01,
        OVL_QUARTER = 2'b10,
        OVL_RSVD    = 2'b11
    } ovl_e;

    // right-shift applied to the block length to get the per-block step
    function automatic logic [1:0] ovl_shift(input logic [1:0] code);
        case (ovl_e'(code))
            OVL_HALF:    return 2'd1;
            OVL_QUARTER: return 2'd2;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/olb_word_pack.sv
module olb_word_pack #(
    parameter int SMP_W = 16
) (
    input  logic [SMP_W-1:0]   re_in,
    input  logic [SMP_W-1:0]   im_in,
    input  logic [SMP_W-1:0]   aux_in,
    input  logic               real_mode,
    output logic [2*SMP_W-1:0] word_out
);

    logic [SMP_W-1:0] upper_half;

    always_comb begin
        upper_half = real_mode ? aux_in : im_in;
        word_out   = {upper_half, re_in};
    end

endmodule

// File: rtl/olb_ws_ram.sv
module olb_ws_ram #(
    parameter int AW = 11,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

    AST_WADDR_KNOWN: assert property (@(posedge clk) we |-> !$isunknown(waddr)); // R3

endmodule

// File: rtl/olb_seq_ctrl.sv
module olb_seq_ctrl
    import olb_pkg::*;
#(
    parameter int MIN_LOG2  = 7,
    parameter int NUM_SIZES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_go,
    input  logic                in_vld,
    input  logic [SZ_W-1:0]     cfg_size,
    input  logic [1:0]          cfg_ovl,
    output logic                we,
    output logic [AW-1:0]       waddr,
    output logic                busy,
    output logic                blk_rdy,
    output logic [AW-1:0]       blk_base
);

    localparam int MAX_LOG2 = MIN_LOG2 + NUM_SIZES - 1;
    localparam int SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1;
    localparam int AW       = MAX_LOG2 + 1;   // workspace is twice the largest block
    localparam int CNT_W    = MAX_LOG2 + 1;

    typedef struct packed {
        logic             busy;
        logic             fresh;
        logic             rdy;
        logic [SZ_W-1:0]  size;
        logic [1:0]       sh;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] need;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    start;
        logic [AW-1:0]    base;
    } seq_st_t;

    seq_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] blk_len(input logic [SZ_W-1:0] code);
        logic [CNT_W-1:0] len;
        len = CNT_W'(1) << MAX_LOG2;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (code == SZ_W'(i)) begin
                len = CNT_W'(1) << (MIN_LOG2 + i);
            end
        end
        return len;
    endfunction

    logic             acc, done, take, restart;
    logic [CNT_W-1:0] len_cur, len_new, step_cur;
    logic [1:0]       sh_new;

    always_comb begin
        len_cur  = blk_len(st_q.size);
        len_new  = blk_len(cfg_size);
        step_cur = len_cur >> st_q.sh;
        sh_new   = ovl_shift(cfg_ovl);

        acc  = st_q.busy && in_vld;
        done = acc && ((st_q.cnt + CNT_W'(1)) == st_q.need);
        take = load_go && (!st_q.busy || done);

        st_d     = st_q;
        st_d.rdy = 1'b0;
        restart  = 1'b0;

        if (acc) begin
            st_d.wp  = st_q.wp + AW'(1);
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (done) begin
            st_d.rdy   = 1'b1;
            st_d.base  = st_q.start;
            st_d.start = st_q.start + AW'(step_cur);
            st_d.busy  = 1'b0;
            st_d.cnt   = '0;
            st_d.fresh = 1'b0;
        end

        if (take) begin
            restart   = st_d.fresh || (cfg_size != st_q.size) || (sh_new != st_q.sh);
            st_d.size = cfg_size;
            st_d.sh   = sh_new;
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            if (restart) begin
                st_d.fresh = 1'b1;
                st_d.need  = len_new;
                st_d.start = st_d.wp;
            end else begin
                st_d.need  = len_new >> sh_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign we       = acc;
    assign waddr    = st_q.wp;
    assign busy     = st_q.busy;
    assign blk_rdy  = st_q.rdy;
    assign blk_base = st_q.base;

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rdy |=> !st_q.rdy); // R8
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> $stable(st_q.wp)); // R2
    AST_CNT_UNDER_NEED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < st_q.need)); // R5
    AST_FRESH_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.fresh) |-> (st_q.need == len_cur)); // R6
    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.fresh) |-> (st_q.need == step_cur)); // R7

endmodule

// File: rtl/ovlp_block_loader.sv
module ovlp_block_loader #(
    parameter int SMP_W     = 16,
    parameter int MIN_LOG2  = 7,
    parameter int NUM_SIZES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   load_go,
    input  logic                                   in_vld,
    input  logic [SMP_W-1:0]                       in_re,
    input  logic [SMP_W-1:0]                       in_im,
    input  logic [SMP_W-1:0]                       in_aux,
    input  logic                                   cfg_real,
    input  logic [((NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1)-1:0] cfg_size,
    input  logic [1:0]                             cfg_ovl,
    input  logic [MIN_LOG2+NUM_SIZES-1:0]          rd_addr,
    output logic                                   busy,
    output logic                                   blk_rdy,
    output logic [MIN_LOG2+NUM_SIZES-1:0]          blk_base,
    output logic [2*SMP_W-1:0]                     rd_data
);

    localparam int AW = MIN_LOG2 + NUM_SIZES;
    localparam int DW = 2 * SMP_W;

    logic          ws_we;
    logic [AW-1:0] ws_waddr;
    logic [DW-1:0] ws_wdata;

    olb_seq_ctrl #(
        .MIN_LOG2  (MIN_LOG2),
        .NUM_SIZES (NUM_SIZES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_go  (load_go),
        .in_vld   (in_vld),
        .cfg_size (cfg_size),
        .cfg_ovl  (cfg_ovl),
        .we       (ws_we),
        .waddr    (ws_waddr),
        .busy     (busy),
        .blk_rdy  (blk_rdy),
        .blk_base (blk_base)
    );

    olb_word_pack #(
        .SMP_W (SMP_W)
    ) u_pack (
        .re_in     (in_re),
        .im_in     (in_im),
        .aux_in    (in_aux),
        .real_mode (cfg_real),
        .word_out  (ws_wdata)
    );

    olb_ws_ram #(
        .AW (AW),
        .DW (DW)
    ) u_ram (
        .clk   (clk),
        .we    (ws_we),
        .waddr (ws_waddr),
        .wdata (ws_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_RDY_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rdy |-> $past(in_vld)); // R8
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ws_waddr)); // R2

endmodule

// File: tb/ovlp_block_loader_bench.sv
`timescale 1ns/1ps
module ovlp_block_loader_bench;

    localparam int MINL  = 7;
    localparam int NS    = 4;
    localparam int AW    = MINL + NS;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_go = 1'b0;
    logic          in_vld = 1'b0;
    logic [15:0]   in_re = '0, in_im = '0, in_aux = '0;
    logic          cfg_real = 1'b0;
    logic [1:0]    cfg_size = '0, cfg_ovl = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy, blk_rdy;
    logic [AW-1:0] blk_base;
    logic [31:0]   rd_data;

    ovlp_block_loader u_ovlp_block_loader (
        .clk(clk), .rst_n(rst_n), .load_go(load_go), .in_vld(in_vld),
        .in_re(in_re), .in_im(in_im), .in_aux(in_aux), .cfg_real(cfg_real),
        .cfg_size(cfg_size), .cfg_ovl(cfg_ovl), .rd_addr(rd_addr),
        .busy(busy), .blk_rdy(blk_rdy), .blk_base(blk_base), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int shf(input logic [1:0] o);
        if (o == 2'b01) return 1;
        if (o == 2'b10) return 2;
        return 0;
    endfunction

    // behavioural reference model
    int          m_busy, m_cnt, m_need, m_wp, m_fresh, m_size, m_sh, m_rdy, m_base, m_n;
    logic [31:0] mem_m [DEPTH];
    bit          seen [DEPTH];
    int          prev_busy;
    bit          m_acc, m_done, m_restart;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_need = 0; m_wp = 0; m_fresh = 1;
            m_size = -1; m_sh = -1; m_rdy = 0; m_base = 0; m_n = 128;
        end else begin
            prev_busy = m_busy;
            m_acc  = (m_busy != 0) && in_vld;
            m_done = m_acc && (m_cnt + 1 == m_need);
            m_rdy  = 0;
            if (m_acc) begin
                mem_m[m_wp] = cfg_real ? {in_aux, in_re} : {in_im, in_re};
                seen[m_wp]  = 1'b1;
                m_wp  = (m_wp + 1) % DEPTH;
                m_cnt = m_cnt + 1;
            end
            if (m_done) begin
                m_rdy = 1; m_base = (m_wp - m_n + DEPTH) % DEPTH;
                m_busy = 0; m_cnt = 0; m_fresh = 0;
            end
            if (load_go && (prev_busy == 0 || m_done)) begin
                m_restart = (m_fresh != 0) || (int'(cfg_size) != m_size) || (shf(cfg_ovl) != m_sh);
                m_n    = 128 << cfg_size;
                m_size = int'(cfg_size);
                m_sh   = shf(cfg_ovl);
                m_need = m_restart ? m_n : (m_n >> m_sh);
                if (m_restart) m_fresh = 1;
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_busy != 0), "R2 busy vs model", int'(busy), m_busy);
            chk(blk_rdy == (m_rdy != 0), "R8 blk_rdy vs model", int'(blk_rdy), m_rdy);
            chk(int'(blk_base) == m_base, "R8 blk_base vs model", int'(blk_base), m_base);
        end
    end

    task automatic readback(input int base, input int num);
        for (int i = 0; i < num; i++) begin
            int a;
            a = (base + i) % DEPTH;
            rd_addr = AW'(a);
            @(negedge clk);
            if (seen[a]) chk(rd_data == mem_m[a], "R11 R3 R4 workspace word", int'(rd_data), int'(mem_m[a]));
        end
    endtask

    task automatic run_combo(input int sz, input int ov, input bit rl, input int nblk, input bit chain);
        int n, stp, start, expb, need, got, cyc;
        bit v;
        cfg_size = 2'(sz); cfg_ovl = 2'(ov); cfg_real = rl;
        n = 128 << sz; stp = n >> shf(2'(ov));
        start = m_wp;
        for (int b = 0; b < nblk; b++) begin
            if (b == 0 || !chain) begin
                in_vld = 1'b1; in_re = 16'($urandom); load_go = 1'b0;
                @(negedge clk);
                chk(busy == 1'b0, "R2 idle sample dropped", int'(busy), 0);
                load_go = 1'b1; in_re = 16'($urandom);
                @(negedge clk);
                load_go = 1'b0; in_vld = 1'b0;
                chk(busy == 1'b1, "R2 armed after strobe", int'(busy), 1);
            end
            need = (b == 0) ? n : stp; got = 0; cyc = 0;
            while (got < need) begin
                v = (cyc % 7) != 3; cyc++;
                in_vld = v; in_re = 16'($urandom); in_im = 16'($urandom); in_aux = 16'($urandom);
                load_go = v && (((got == need - 1) && chain && (b < nblk - 1)) || (got == need / 2));
                @(negedge clk);
                if (v) got++;
                if (got < need) chk(blk_rdy == 1'b0, "R5 no early ready", int'(blk_rdy), 0);
            end
            in_vld = 1'b0; load_go = 1'b0;
            expb = (start + b * stp) % DEPTH;
            chk(blk_rdy == 1'b1, "R8 ready after last sample", int'(blk_rdy), 1);
            if (b == 0) chk(int'(blk_base) == expb, "R6 R10 full first block base", int'(blk_base), expb);
            else        chk(int'(blk_base) == expb, "R7 overlapped block base", int'(blk_base), expb);
            chk(busy == (chain && b < nblk - 1), "R9 chained busy", int'(busy), int'(chain && b < nblk - 1));
            @(negedge clk);
            chk(blk_rdy == 1'b0, "R8 single cycle pulse", int'(blk_rdy), 0);
            chk(int'(blk_base) == expb, "R8 base held", int'(blk_base), expb);
            if (b == nblk - 1) begin
                readback(expb, 6);
                readback((expb + n - 6) % DEPTH, 6);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(blk_rdy == 1'b0, "R1 reset ready", int'(blk_rdy), 0);
        chk(blk_base == '0, "R1 reset base", int'(blk_base), 0);
        chk(m_wp == 0, "R1 first write address", m_wp, 0);
        for (int sz = 0; sz < 4; sz++) begin
            for (int ov = 0; ov < 3; ov++) begin
                run_combo(sz, ov, 1'((sz + ov) % 2), (ov == 0) ? 3 : 4, (ov == 2) || (sz % 2 == 1));
            end
        end
        run_combo(0, 3, 1'b1, 3, 1'b0);
        run_combo(0, 0, 1'b0, 2, 1'b1);
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule